// File: doc/BRIEF.md
# Synchronous Pipelined Dual-Port Memory

This block is a true dual-port synchronous static memory. Each side has its own clock, its own inputs and its own output register. The default build holds 2^10 words of 9 bits, and `ADDR_W = 15` gives the full 32768-word array. Either side can read or write any word at any time. A side registers its controls on the rising edge of its clock and returns read data one edge later, through a pipeline output register.

Each side owns a burst address counter. The counter can be loaded from the external address, stepped by one per clock, held, or cleared, so a single load can start a sequential burst. Each side also has two chip selects of opposite polarity. These let several instances be banked in depth, with an upper address bit driving the selects, or in width, with the same controls shared across instances. An output enable gates the read data without any clock.

Top module: `dpr_pipe_ram`

## Requirements
- R1: A selected read (`x_rnw` = 1) registered at edge k puts the word at the access address on `x_q`, with `x_q_drive` = 1, just after edge k+1, provided `x_oe_n` is low.
- R2: A selected write (`x_rnw` = 0) registered at edge k stores `x_din` at the access address. A read from either side that is registered at edge k+1 or later returns the new word. The output is not driven just after the edge that follows a write cycle.
- R3: A side is selected only when `x_en_n` = 0 and `x_en` = 1. A cycle registered with either select inactive writes nothing, and `x_q_drive` is 0 after the next edge.
- R4: After a deselected cycle, the outputs drive again only after two edges with the side selected for a read: the edge that registers the read, and the edge that follows it.
- R5: `x_oe_n` high forces `x_q_drive` to 0 and `x_q` to 0 without waiting for a clock edge. Taking it low restores the registered output at once.
- R6: With `x_clr_n` high and `x_load_n` low, the access address registered at that edge is `x_addr`.
- R7: With `x_clr_n` and `x_load_n` high and `x_step_n` low, the access address is the previous one plus 1, and it wraps from 2^ADDR_W-1 to 0.
- R8: With `x_clr_n`, `x_load_n` and `x_step_n` all high, the access address is unchanged.
- R9: `x_clr_n` low sets the access address to 0 at that edge. This takes priority over load and step.
- R10: The two sides are independent. A word written through one side is read back through the other.
- R11: When one side reads a word that the other side writes, and both commands are registered at the same edge, the read returns the old word.
- R12: The synchronous active-high `rst` clears both counters to address 0 and leaves both outputs undriven. It does not clear the stored words.

The counters run on every edge, whether or not the side is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| a_clk | input | 1 | Side A clock |
| a_addr | input | ADDR_W | Side A external address for counter load |
| a_din | input | DATA_W | Side A write data |
| a_rnw | input | 1 | Side A direction: 1 read, 0 write |
| a_en_n | input | 1 | Side A active-low select |
| a_en | input | 1 | Side A active-high select |
| a_load_n | input | 1 | Side A counter load, active low |
| a_step_n | input | 1 | Side A counter step, active low |
| a_clr_n | input | 1 | Side A counter clear, active low |
| a_oe_n | input | 1 | Side A asynchronous output enable, active low |
| a_q | output | DATA_W | Side A read data, 0 when not driven |
| a_q_drive | output | 1 | Side A output-valid/drive flag |
| b_clk | input | 1 | Side B clock |
| b_addr | input | ADDR_W | Side B external address for counter load |
| b_din | input | DATA_W | Side B write data |
| b_rnw | input | 1 | Side B direction: 1 read, 0 write |
| b_en_n | input | 1 | Side B active-low select |
| b_en | input | 1 | Side B active-high select |
| b_load_n | input | 1 | Side B counter load, active low |
| b_step_n | input | 1 | Side B counter step, active low |
| b_clr_n | input | 1 | Side B counter clear, active low |
| b_oe_n | input | 1 | Side B asynchronous output enable, active low |
| b_q | output | DATA_W | Side B read data, 0 when not driven |
| b_q_drive | output | 1 | Side B output-valid/drive flag |

## Verification
A wrong counter value stays hidden until the next read on that side. It then shows one edge later as a word from a neighbouring address, so burst reads across the wrap point and hold/clear sequences expose it within two edges. A bad entry in either storage bank corrupts the combined word seen by both sides, and reads through the opposite side catch it. A wrong valid flag in the pipeline shows on `x_q_drive` right after the edge that follows a deselected or write cycle.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int unsigned PORTS = 2;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_INC  = 2'd1,
        CNT_LOAD = 2'd2,
        CNT_CLR  = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic step_n;
        logic en_n;
        logic en;
        logic rnw;
    } port_ctl_t;

    // clear beats load, load beats step
    function automatic cnt_op_e cnt_decode(input logic clr_n, input logic load_n,
                                           input logic step_n);
        cnt_op_e op;
        if (!clr_n)       op = CNT_CLR;
        else if (!load_n) op = CNT_LOAD;
        else if (!step_n) op = CNT_INC;
        else              op = CNT_HOLD;
        return op;
    endfunction

    function automatic logic port_selected(input logic en_n, input logic en);
        return (!en_n) && en;
    endfunction

endpackage

// File: rtl/dpr_addr_counter.sv
module dpr_addr_counter
    import dpr_pkg::*;
#(
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  cnt_op_e       op,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] cnt
);

    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (op)
                CNT_CLR:  cnt <= '0;
                CNT_LOAD: cnt <= load_val;
                CNT_INC:  cnt <= cnt + ONE;
                default:  cnt <= cnt;
            endcase
        end
    end

    // R9
    cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CNT_CLR) |=> (cnt == '0));

    // R6
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CNT_LOAD) |=> (cnt == $past(load_val)));

    // R7
    cnt_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CNT_INC) |=> (cnt == $past(cnt) + ONE));

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CNT_HOLD) |=> $stable(cnt));

endmodule

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
    import dpr_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  port_ctl_t     ctl,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] acc_addr,
    output logic          acc_rd,
    output logic          acc_wr,
    output logic [DW-1:0] acc_din
);

    typedef struct packed {
        logic          rd;
        logic          wr;
        logic [DW-1:0] data;
    } stage_t;

    stage_t  stg;
    cnt_op_e op;
    logic    sel;

    assign op  = cnt_decode(ctl.clr_n, ctl.load_n, ctl.step_n);
    assign sel = port_selected(ctl.en_n, ctl.en);

    // the counter doubles as the registered access address
    dpr_addr_counter #(.AW(AW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (addr),
        .cnt      (acc_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg.rd   <= sel && ctl.rnw;
            stg.wr   <= sel && !ctl.rnw;
            stg.data <= din;
        end
    end

    assign acc_rd  = stg.rd;
    assign acc_wr  = stg.wr;
    assign acc_din = stg.data;

    // R3
    desel_stage_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (!acc_rd && !acc_wr));

endmodule

// File: rtl/dpr_bank.sv
module dpr_bank
    import dpr_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 9
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [DW-1:0]             wdata,
    input  logic [PORTS-1:0][AW-1:0]  raddr,
    output logic [PORTS-1:0][DW-1:0]  rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar r = 0; r < PORTS; r++) begin : g_rd
        assign rdata[r] = mem[raddr[r]];
    end

endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage #(
    parameter int unsigned DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_data,
    input  logic          oe_n,
    output logic [DW-1:0] q,
    output logic          q_drive
);

    logic          vld;
    logic [DW-1:0] q_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld   <= 1'b0;
            q_reg <= '0;
        end else begin
            vld <= ld_valid;
            if (ld_valid) begin
                q_reg <= ld_data;
            end
        end
    end

    assign q_drive = vld && !oe_n;
    assign q       = q_drive ? q_reg : '0;

    always_comb begin
        // R5
        if (oe_n) begin
            oe_off_chk: assert (q_drive == 1'b0 && q == '0);
        end
    end

    // R3
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |=> !q_drive);

endmodule

// File: rtl/dpr_pipe_ram.sv
module dpr_pipe_ram
    import dpr_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 9
) (
    input  logic              rst,
    input  logic              a_clk,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_din,
    input  logic              a_rnw,
    input  logic              a_en_n,
    input  logic              a_en,
    input  logic              a_load_n,
    input  logic              a_step_n,
    input  logic              a_clr_n,
    input  logic              a_oe_n,
    output logic [DATA_W-1:0] a_q,
    output logic              a_q_drive,
    input  logic              b_clk,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_din,
    input  logic              b_rnw,
    input  logic              b_en_n,
    input  logic              b_en,
    input  logic              b_load_n,
    input  logic              b_step_n,
    input  logic              b_clr_n,
    input  logic              b_oe_n,
    output logic [DATA_W-1:0] b_q,
    output logic              b_q_drive
);

    logic [PORTS-1:0]                    clk_v;
    port_ctl_t [PORTS-1:0]               ctl_v;
    logic [PORTS-1:0][ADDR_W-1:0]        addr_v;
    logic [PORTS-1:0][DATA_W-1:0]        din_v;
    logic [PORTS-1:0]                    oe_v;
    logic [PORTS-1:0][DATA_W-1:0]        q_v;
    logic [PORTS-1:0]                    drv_v;

    logic [PORTS-1:0][ADDR_W-1:0]        acc_addr;
    logic [PORTS-1:0]                    acc_rd;
    logic [PORTS-1:0]                    acc_wr;
    logic [PORTS-1:0][DATA_W-1:0]        acc_din;
    // rd[bank][port]: word of a bank at a side's access address
    logic [PORTS-1:0][PORTS-1:0][DATA_W-1:0] rd;

    assign clk_v  = {b_clk, a_clk};
    assign addr_v = {b_addr, a_addr};
    assign din_v  = {b_din, a_din};
    assign oe_v   = {b_oe_n, a_oe_n};
    assign ctl_v[0] = '{clr_n: a_clr_n, load_n: a_load_n, step_n: a_step_n,
                        en_n: a_en_n, en: a_en, rnw: a_rnw};
    assign ctl_v[1] = '{clr_n: b_clr_n, load_n: b_load_n, step_n: b_step_n,
                        en_n: b_en_n, en: b_en, rnw: b_rnw};

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        localparam int unsigned OTHER = PORTS - 1 - p;

        dpr_port_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
            .clk      (clk_v[p]),
            .rst      (rst),
            .ctl      (ctl_v[p]),
            .addr     (addr_v[p]),
            .din      (din_v[p]),
            .acc_addr (acc_addr[p]),
            .acc_rd   (acc_rd[p]),
            .acc_wr   (acc_wr[p]),
            .acc_din  (acc_din[p])
        );

        // each side owns one bank; stored word is the XOR of both banks
        dpr_bank #(.AW(ADDR_W), .DW(DATA_W)) u_bank (
            .clk   (clk_v[p]),
            .we    (acc_wr[p]),
            .waddr (acc_addr[p]),
            .wdata (acc_din[p] ^ rd[OTHER][p]),
            .raddr (acc_addr),
            .rdata (rd[p])
        );

        dpr_out_stage #(.DW(DATA_W)) u_out (
            .clk      (clk_v[p]),
            .rst      (rst),
            .ld_valid (acc_rd[p]),
            .ld_data  (rd[0][p] ^ rd[1][p]),
            .oe_n     (oe_v[p]),
            .q        (q_v[p]),
            .q_drive  (drv_v[p])
        );

        // R3
        desel_out_chk: assert property (@(posedge clk_v[p]) disable iff (rst)
            !port_selected(ctl_v[p].en_n, ctl_v[p].en) |=> ##1 !drv_v[p]);

        // R1
        rd_out_chk: assert property (@(posedge clk_v[p]) disable iff (rst)
            (port_selected(ctl_v[p].en_n, ctl_v[p].en) && ctl_v[p].rnw)
            |=> ##1 (drv_v[p] == !oe_v[p]));
    end

    assign a_q       = q_v[0];
    assign a_q_drive = drv_v[0];
    assign b_q       = q_v[1];
    assign b_q_drive = drv_v[1];

endmodule

// File: tb/sim_dpr_pipe_ram.sv
module sim_dpr_pipe_ram;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int DW    = 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          rst;
    logic [AW-1:0] s_addr [2];
    logic [DW-1:0] s_din  [2];
    logic          s_rnw  [2];
    logic          s_en_n [2];
    logic          s_en   [2];
    logic          s_ld_n [2];
    logic          s_st_n [2];
    logic          s_cl_n [2];
    logic          s_oe_n [2];
    logic [DW-1:0] s_q    [2];
    logic          s_drv  [2];

    dpr_pipe_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .rst       (rst),
        .a_clk     (clk),
        .a_addr    (s_addr[0]),
        .a_din     (s_din[0]),
        .a_rnw     (s_rnw[0]),
        .a_en_n    (s_en_n[0]),
        .a_en      (s_en[0]),
        .a_load_n  (s_ld_n[0]),
        .a_step_n  (s_st_n[0]),
        .a_clr_n   (s_cl_n[0]),
        .a_oe_n    (s_oe_n[0]),
        .a_q       (s_q[0]),
        .a_q_drive (s_drv[0]),
        .b_clk     (clk),
        .b_addr    (s_addr[1]),
        .b_din     (s_din[1]),
        .b_rnw     (s_rnw[1]),
        .b_en_n    (s_en_n[1]),
        .b_en      (s_en[1]),
        .b_load_n  (s_ld_n[1]),
        .b_step_n  (s_st_n[1]),
        .b_clr_n   (s_cl_n[1]),
        .b_oe_n    (s_oe_n[1]),
        .b_q       (s_q[1]),
        .b_q_drive (s_drv[1])
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [DW-1:0] exp_mem [DEPTH];

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return DW'((a * 37 + s * 101 + 13) % 512);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int p);
        s_en_n[p] = 1'b1; s_en[p] = 1'b0; s_rnw[p] = 1'b1;
        s_ld_n[p] = 1'b1; s_st_n[p] = 1'b1; s_cl_n[p] = 1'b1;
    endtask

    task automatic cmd(input int p, input bit wr, input bit ld, input bit st,
                       input int a, input int d);
        s_en_n[p] = 1'b0; s_en[p] = 1'b1; s_rnw[p] = !wr;
        s_ld_n[p] = !ld;  s_st_n[p] = !st; s_cl_n[p] = 1'b1;
        s_addr[p] = AW'(a); s_din[p] = DW'(d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [DW-1:0] oldv, newv;
        rst = 1'b1;
        for (int p = 0; p < 2; p++) begin
            idle(p); s_oe_n[p] = 1'b0; s_addr[p] = '0; s_din[p] = '0;
        end
        tick(); tick(); tick();
        rst = 1'b0;
        // R12 reset state
        chk("R12 a_drive after reset", s_drv[0], 0);
        chk("R12 b_drive after reset", s_drv[1], 0);

        // R2 R6: side A writes every address with a load per word
        for (int a = 0; a < DEPTH; a++) begin
            cmd(0, 1, 1, 0, a, pat(a, 1));
            exp_mem[a] = pat(a, 1);
            tick();
            if (a > 0) chk("R2 no drive after write", s_drv[0], 0);
        end
        idle(0);

        // R10 R1: side B pipelined reads of every address
        for (int a = 0; a < DEPTH; a++) begin
            cmd(1, 0, 1, 0, a, 0);
            tick();
            if (a > 0) begin
                chk("R10 b read of a-written word", s_q[1], exp_mem[a-1]);
                chk("R1 b drive", s_drv[1], 1);
            end
        end
        idle(1);
        tick();
        chk("R10 b last word", s_q[1], exp_mem[DEPTH-1]);

        // R7: side B burst write from 5 with wrap, loaded once
        cmd(1, 1, 1, 0, 5, pat(5, 2));
        exp_mem[5] = pat(5, 2);
        tick();
        for (int i = 1; i < DEPTH; i++) begin
            cmd(1, 1, 0, 1, 0, pat((5 + i) % DEPTH, 2));
            exp_mem[(5 + i) % DEPTH] = pat((5 + i) % DEPTH, 2);
            tick();
        end
        idle(1);

        // R7 R10: side A burst read from 12 across the wrap point
        cmd(0, 0, 1, 0, 12, 0);
        tick();
        for (int i = 1; i < DEPTH; i++) begin
            cmd(0, 0, 0, 1, 0, 0);
            tick();
            chk("R7 burst read", s_q[0], exp_mem[(12 + i - 1) % DEPTH]);
        end
        idle(0);
        tick();
        chk("R7 burst last", s_q[0], exp_mem[(12 + DEPTH - 1) % DEPTH]);

        // R8: hold
        cmd(0, 0, 1, 0, 9, 0);
        tick();
        for (int i = 0; i < 3; i++) begin
            cmd(0, 0, 0, 0, 3, 0);
            tick();
            chk("R8 hold address", s_q[0], exp_mem[9]);
        end
        idle(0);
        tick();

        // R9: clear wins over load and step
        cmd(0, 0, 1, 1, 7, 0);
        s_cl_n[0] = 1'b0;
        tick();
        idle(0);
        tick();
        chk("R9 clear priority", s_q[0], exp_mem[0]);
        chk("R9 drive", s_drv[0], 1);

        // R3: deselected writes are ignored
        cmd(0, 1, 1, 0, 2, 9'h0AA);
        s_en_n[0] = 1'b1;
        tick();
        cmd(0, 1, 1, 0, 4, 9'h055);
        s_en[0] = 1'b0;
        tick();
        cmd(0, 0, 1, 0, 2, 0);
        tick();
        cmd(0, 0, 1, 0, 4, 0);
        tick();
        chk("R3 addr2 unchanged", s_q[0], exp_mem[2]);
        idle(0);
        tick();
        chk("R3 addr4 unchanged", s_q[0], exp_mem[4]);
        cmd(0, 0, 1, 0, 6, 0);
        s_en_n[0] = 1'b1;
        tick();
        idle(0);
        tick();
        chk("R3 deselected read not driven", s_drv[0], 0);

        // R4: reactivation after a deselected cycle
        cmd(0, 0, 1, 0, 6, 0);
        tick();
        idle(0);
        tick();
        chk("R4 word before deselect", s_q[0], exp_mem[6]);
        cmd(0, 0, 1, 0, 8, 0);
        tick();
        chk("R4 still undriven after first selected edge", s_drv[0], 0);
        idle(0);
        tick();
        chk("R4 driven after second edge", s_drv[0], 1);
        chk("R4 word after reactivation", s_q[0], exp_mem[8]);

        // R5: asynchronous output enable
        s_oe_n[0] = 1'b1;
        #1;
        chk("R5 oe high drive", s_drv[0], 0);
        chk("R5 oe high q", s_q[0], 0);
        s_oe_n[0] = 1'b0;
        #1;
        chk("R5 oe low drive", s_drv[0], 1);
        chk("R5 oe low q", s_q[0], exp_mem[8]);

        // R2: write on A then read on B registered one edge later
        cmd(0, 1, 1, 0, 10, pat(10, 3));
        tick();
        idle(0);
        cmd(1, 0, 1, 0, 10, 0);
        tick();
        idle(1);
        tick();
        exp_mem[10] = pat(10, 3);
        chk("R2 new word visible next cycle", s_q[1], exp_mem[10]);

        // R11: same-edge write on A and read on B returns old
        oldv = exp_mem[3];
        newv = pat(3, 4);
        cmd(0, 1, 1, 0, 3, newv);
        cmd(1, 0, 1, 0, 3, 0);
        tick();
        idle(0); idle(1);
        tick();
        chk("R11 b old word", s_q[1], oldv);
        exp_mem[3] = newv;
        cmd(1, 0, 1, 0, 3, 0);
        tick();
        idle(1);
        tick();
        chk("R11 b new word afterwards", s_q[1], newv);

        // R11: reverse direction, B writes and A reads
        oldv = exp_mem[12];
        newv = pat(12, 5);
        cmd(1, 1, 1, 0, 12, newv);
        cmd(0, 0, 1, 0, 12, 0);
        tick();
        idle(0); idle(1);
        tick();
        chk("R11 a old word", s_q[0], oldv);
        exp_mem[12] = newv;

        // R12: reset clears counters to 0, keeps stored words
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        chk("R12 a_drive after second reset", s_drv[0], 0);
        chk("R12 b_drive after second reset", s_drv[1], 0);
        cmd(0, 0, 0, 0, 11, 0);
        cmd(1, 0, 0, 0, 11, 0);
        tick();
        idle(0); idle(1);
        tick();
        chk("R12 a counter at zero", s_q[0], exp_mem[0]);
        chk("R12 b counter at zero", s_q[1], exp_mem[0]);

        finish_run();
    end

endmodule